// File: doc/BRIEF.md
# Peripheral Block Transfer Sequencer

This block paces the peripheral side of a DMA job when its channel runs in peripheral mode. A kick pulse latches the job: element size, block length, which of twelve peripherals is served, and the total element count. The sequencer then waits for that peripheral's request and answers each request with one block of element strobes, one element per cycle. While the block runs it counts the elements that remain in it. Between blocks it waits for the request again.

If the clear option is set, the selected peripheral receives a single-cycle clear pulse as the job begins, before any element moves. When the element count runs out, the job ends at once, even in the middle of a block, and a one-cycle done pulse follows. Packing data into memory words and generating addresses belong to neighbouring blocks.

Top module: `periph_block_seq`

## Requirements
- R1: After synchronous reset, `busy`, `elem_strobe`, `job_done` and `per_clear` are low, and `blk_left` and `lane_size` are 0.
- R2: A `kick` is accepted only when `mode_periph` is 1 and `per_sel` is between 0 and 11. A kick with `mode_periph` = 0 (memory mode), or with `per_sel` of 12 or more, is ignored: `busy`, `elem_strobe` and `job_done` stay low.
- R3: `lane_size` gives the log2 of the element byte width latched at the kick. Size code 0 (32-bit) gives 2, code 1 (16-bit) gives 1, code 2 (8-bit) gives 0, and the reserved code 3 gives 2.
- R4: Strobes come in contiguous runs, one element per cycle. Each run is `blk_size` elements long, where code 0 means 64. Only the last run of a job may be shorter.
- R5: A block starts only in the cycle after `per_req[per_sel]` is seen high while the sequencer waits. While that bit stays low, no strobe occurs, even if other request bits are high.
- R6: `blk_left` holds the full block length while waiting. On each strobe it shows the elements left in the block, counting the current one. It reloads after each full block and returns to 0 when the job ends.
- R7: The job makes exactly `job_len` strobes. `job_done` pulses for one cycle in the cycle right after the last strobe, without waiting for another request.
- R8: A kick with `job_len` = 0 gives a `job_done` pulse in the next cycle and no strobe.
- R9: With `clr_en` set, `per_clear` is one-hot at the selected peripheral for exactly the one cycle after the kick, before the first strobe. With `clr_en` clear, `per_clear` stays 0.
- R10: `busy` is high from the cycle after an accepted kick through the last strobe, and it is low when `job_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Job start pulse |
| mode_periph | input | 1 | 1 = peripheral mode, 0 = memory mode |
| elem_code | input | 2 | Element size code |
| blk_size | input | 6 | Block length in elements, 0 means 64 |
| per_sel | input | 4 | Served peripheral index |
| job_len | input | 18 | Total elements in the job |
| clr_en | input | 1 | Emit a clear pulse at job start |
| per_req | input | 12 | Request line of each peripheral |
| per_clear | output | 12 | One-hot read/write clear pulse |
| elem_strobe | output | 1 | One element moves this cycle |
| lane_size | output | 2 | log2 of element byte width |
| blk_left | output | 8 | Elements left in the current block |
| busy | output | 1 | Job in progress |
| job_done | output | 1 | One-cycle job completion pulse |

## Verification
Jobs are run with each of the four size codes. Each job pairs a length and a block size so that it ends either in the middle of a block or exactly on a block boundary. These runs separate correct run lengths and reload of the offset count from an off-by-one at either end. A 64-element block checks the zero-means-full encoding. A request held low, with another peripheral's request high, shows that the sequencer waits on the right request line. In a job that ends on a block boundary, the request is dropped inside the final block, which shows that the end of the job does not wait for a request. Memory-mode kicks, out-of-range selects and zero-length jobs confirm that the start conditions are decoded correctly, and a clear-enabled job pins the position of the clear pulse.

// File: rtl/periph_seq_pkg.sv
package periph_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLR  = 2'd1,
    ST_WAIT = 2'd2,
    ST_MOVE = 2'd3
  } seq_state_t;

  localparam logic [1:0] LANE_B1 = 2'd0;
  localparam logic [1:0] LANE_B2 = 2'd1;
  localparam logic [1:0] LANE_B4 = 2'd2;
endpackage

// File: rtl/psq_lane_dec.sv
module psq_lane_dec
  import periph_seq_pkg::*;
(
  input  logic [1:0] code,
  output logic [1:0] lane
);
  always_comb begin
    case (code)
      2'd1:    lane = LANE_B2;
      2'd2:    lane = LANE_B1;
      default: lane = LANE_B4; // code 0 and reserved code 3
    endcase
  end
endmodule

// File: rtl/psq_req_pick.sv
module psq_req_pick #(
  parameter int NPER = 12,
  parameter int SELW = 4
) (
  input  logic [NPER-1:0] req,
  input  logic [SELW-1:0] sel,
  output logic            hit,
  output logic            sel_ok
);
  logic [NPER-1:0] match;

  for (genvar i = 0; i < NPER; i++) begin : g_match
    assign match[i] = req[i] & (sel == SELW'(i));
  end

  assign hit    = |match;
  assign sel_ok = (sel < SELW'(NPER));
endmodule

// File: rtl/psq_blk_ctr.sv
module psq_blk_ctr #(
  parameter int BSZW = 6,
  parameter int OFSW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            dec,
  input  logic            clear,
  input  logic [BSZW-1:0] size_code,
  output logic [OFSW-1:0] cnt
);
  localparam int FULL = 1 << BSZW;

  logic [OFSW-1:0] len;
  assign len = (size_code == '0) ? OFSW'(FULL) : OFSW'(size_code);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (load)    cnt <= len;
    else if (dec)     cnt <= cnt - OFSW'(1);
  end

  // R6
  ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= OFSW'(FULL));
endmodule

// File: rtl/periph_block_seq.sv
module periph_block_seq
  import periph_seq_pkg::*;
#(
  parameter int NPER = 12,
  parameter int SELW = 4,
  parameter int BSZW = 6,
  parameter int JOBW = 18,
  parameter int OFSW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kick,
  input  logic            mode_periph,
  input  logic [1:0]      elem_code,
  input  logic [BSZW-1:0] blk_size,
  input  logic [SELW-1:0] per_sel,
  input  logic [JOBW-1:0] job_len,
  input  logic            clr_en,
  input  logic [NPER-1:0] per_req,
  output logic [NPER-1:0] per_clear,
  output logic            elem_strobe,
  output logic [1:0]      lane_size,
  output logic [OFSW-1:0] blk_left,
  output logic            busy,
  output logic            job_done
);
  seq_state_t      state;
  logic [JOBW-1:0] job_left;
  logic [SELW-1:0] sel_q;
  logic [BSZW-1:0] bsz_q;
  logic [1:0]      lane_in;
  logic [SELW-1:0] pick_sel;
  logic            req_hit, sel_ok, go, last_elem, blk_end;
  logic            ctr_load, ctr_dec, ctr_clear;
  logic [BSZW-1:0] ctr_code;

  psq_lane_dec u_lane (.code(elem_code), .lane(lane_in));

  assign pick_sel = (state == ST_IDLE) ? per_sel : sel_q;

  psq_req_pick #(.NPER(NPER), .SELW(SELW)) u_pick (
    .req(per_req), .sel(pick_sel), .hit(req_hit), .sel_ok(sel_ok));

  assign go        = (state == ST_IDLE) && kick && mode_periph && sel_ok;
  assign last_elem = (job_left == JOBW'(1));
  assign blk_end   = (blk_left == OFSW'(1));
  assign ctr_code  = (state == ST_IDLE) ? blk_size : bsz_q;
  assign ctr_load  = (go && job_len != '0) ||
                     (state == ST_MOVE && !last_elem && blk_end);
  assign ctr_dec   = (state == ST_MOVE) && !last_elem && !blk_end;
  assign ctr_clear = (state == ST_MOVE) && last_elem;

  psq_blk_ctr #(.BSZW(BSZW), .OFSW(OFSW)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .dec(ctr_dec), .clear(ctr_clear),
    .size_code(ctr_code), .cnt(blk_left));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      job_left    <= '0;
      sel_q       <= '0;
      bsz_q       <= '0;
      lane_size   <= '0;
      elem_strobe <= 1'b0;
      job_done    <= 1'b0;
      per_clear   <= '0;
    end else begin
      job_done  <= 1'b0;
      per_clear <= '0;
      case (state)
        ST_IDLE: if (go) begin
          sel_q     <= per_sel;
          bsz_q     <= blk_size;
          lane_size <= lane_in;
          job_left  <= job_len;
          if (job_len == '0) begin
            job_done <= 1'b1;
          end else if (clr_en) begin
            per_clear <= NPER'(1) << per_sel;
            state     <= ST_CLR;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_CLR: state <= ST_WAIT;
        ST_WAIT: if (req_hit) begin
          state       <= ST_MOVE;
          elem_strobe <= 1'b1;
        end
        ST_MOVE: begin
          job_left <= job_left - JOBW'(1);
          if (last_elem) begin
            elem_strobe <= 1'b0;
            job_done    <= 1'b1;
            state       <= ST_IDLE;
          end else if (blk_end) begin
            elem_strobe <= 1'b0;
            state       <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R10
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    elem_strobe |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    job_done |=> !job_done);

  // R7
  done_nostrobe_chk: assert property (@(posedge clk) disable iff (rst)
    job_done |-> !elem_strobe);

  // R9
  clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_clear));

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|per_clear) |=> (per_clear == '0));

  // R5
  blk_start_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(elem_strobe) |-> $past(req_hit));
endmodule

// File: tb/sim_periph_block_seq.sv
module sim_periph_block_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kick = 1'b0;
  logic        mode_periph = 1'b0;
  logic [1:0]  elem_code = '0;
  logic [5:0]  blk_size = '0;
  logic [3:0]  per_sel = '0;
  logic [17:0] job_len = '0;
  logic        clr_en = 1'b0;
  logic [11:0] per_req = '0;
  logic [11:0] per_clear;
  logic        elem_strobe;
  logic [1:0]  lane_size;
  logic [7:0]  blk_left;
  logic        busy;
  logic        job_done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  periph_block_seq u0 (
    .clk(clk), .rst(rst), .kick(kick), .mode_periph(mode_periph),
    .elem_code(elem_code), .blk_size(blk_size), .per_sel(per_sel),
    .job_len(job_len), .clr_en(clr_en), .per_req(per_req),
    .per_clear(per_clear), .elem_strobe(elem_strobe), .lane_size(lane_size),
    .blk_left(blk_left), .busy(busy), .job_done(job_done));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick_job(bit md, int code, int bsz, int sel, int len, bit ce);
    @(negedge clk);
    mode_periph = md; elem_code = 2'(code); blk_size = 6'(bsz);
    per_sel = 4'(sel); job_len = 18'(len); clr_en = ce; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Follows a running job until done; req bits are cleared after drop_at strobes
  task automatic watch(int blk, int len, int lane, int drop_at, string tag);
    int total = 0, run = 0, remaining = len, cyc = 0, last = -10;
    int donec = -1, ndone = 0, bad_run = 0, bad_ofs = 0, bad_lane = 0, exp;
    bit prev = 1'b0;
    while (cyc < 2000 && ndone == 0) begin
      @(negedge clk);
      cyc++;
      if (elem_strobe) begin
        run++; total++; last = cyc;
        if (int'(blk_left) != blk - run + 1) bad_ofs++;
        if (int'(lane_size) != lane) bad_lane++;
        if (total == drop_at) per_req = '0;
      end else if (prev) begin
        exp = (remaining < blk) ? remaining : blk;
        if (run != exp) bad_run++;
        remaining -= run;
        run = 0;
      end
      if (job_done) begin ndone++; donec = cyc; end
      prev = elem_strobe;
    end
    $display("  job %s: %0d strobes", tag, total);
    check(total == len, "R7 strobe total", total, len);
    check(donec == last + 1, "R7 done right after last strobe", donec, last + 1);
    check(bad_run == 0, "R4 run lengths", bad_run, 0);
    check(bad_ofs == 0, "R6 block offset", bad_ofs, 0);
    check(bad_lane == 0, "R3 lane size", bad_lane, 0);
    check(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
    check(blk_left == 8'd0, "R6 offset cleared at end", int'(blk_left), 0);
  endtask

  task automatic t_reset();
    check(!busy && !elem_strobe && !job_done && per_clear == '0 &&
          blk_left == 8'd0 && lane_size == 2'd0, "R1 reset state",
          int'({busy, elem_strobe, job_done}), 0);
  endtask

  task automatic t_basic();
    per_req = 12'h008;
    kick_job(1'b1, 0, 4, 3, 10, 1'b0);
    check(busy == 1'b1, "R10 busy after kick", int'(busy), 1);
    check(per_clear == '0, "R9 no clear when disabled", int'(per_clear), 0);
    watch(4, 10, 2, 0, "32-bit partial end");
  endtask

  task automatic t_sizes();
    per_req = 12'h020;
    kick_job(1'b1, 1, 3, 5, 7, 1'b0);
    watch(3, 7, 1, 0, "16-bit");
    per_req = 12'h800;
    kick_job(1'b1, 2, 5, 11, 5, 1'b0);
    watch(5, 5, 0, 0, "8-bit single block");
    per_req = 12'h001;
    kick_job(1'b1, 3, 2, 0, 3, 1'b0);
    watch(2, 3, 2, 0, "reserved code as 32-bit");
  endtask

  task automatic t_full_block();
    per_req = 12'h080;
    kick_job(1'b1, 0, 0, 7, 70, 1'b0);
    watch(64, 70, 2, 0, "64-element blocks");
  endtask

  task automatic t_stall();
    int strobes = 0;
    per_req = 12'h010; // only peripheral 4 requests; 6 is selected
    kick_job(1'b1, 0, 6, 6, 9, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (elem_strobe) strobes++;
    end
    check(strobes == 0, "R5 no strobe without own request", strobes, 0);
    check(busy == 1'b1, "R5 waiting stays busy", int'(busy), 1);
    check(blk_left == 8'd6, "R6 full block while waiting", int'(blk_left), 6);
    per_req = 12'h040;
    watch(6, 9, 2, 0, "stalled then released");
  endtask

  task automatic t_exact_end();
    per_req = 12'h004;
    kick_job(1'b1, 0, 4, 2, 8, 1'b0);
    watch(4, 8, 2, 5, "boundary end, request dropped"); // R7
  endtask

  task automatic t_clear();
    per_req = 12'h200;
    kick_job(1'b1, 0, 2, 9, 4, 1'b1);
    check(per_clear == 12'h200, "R9 clear pulse on selected", int'(per_clear), 'h200);
    check(elem_strobe == 1'b0, "R9 clear before first strobe", int'(elem_strobe), 0);
    @(negedge clk);
    check(per_clear == '0, "R9 clear lasts one cycle", int'(per_clear), 0);
    watch(2, 4, 2, 0, "with clear");
  endtask

  task automatic t_ignored();
    int seen = 0;
    per_req = '1;
    kick_job(1'b0, 0, 4, 1, 5, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || elem_strobe || job_done || per_clear != '0) seen++;
    end
    check(seen == 0, "R2 memory-mode kick ignored", seen, 0);
    seen = 0;
    kick_job(1'b1, 0, 4, 12, 5, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || elem_strobe || job_done || per_clear != '0) seen++;
    end
    check(seen == 0, "R2 out-of-range select ignored", seen, 0);
  endtask

  task automatic t_zero();
    per_req = '1;
    kick_job(1'b1, 0, 4, 1, 0, 1'b0);
    check(job_done == 1'b1, "R8 zero-length done", int'(job_done), 1);
    check(busy == 1'b0 && elem_strobe == 1'b0, "R8 zero-length idle",
          int'({busy, elem_strobe}), 0);
    @(negedge clk);
    check(job_done == 1'b0 && elem_strobe == 1'b0, "R8 single done pulse",
          int'({job_done, elem_strobe}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_full_block();
    t_stall();
    t_exact_end();
    t_clear();
    t_ignored();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule